// File: doc/BRIEF.md
# Shifted-Operand ALU with Condition Flags

This block is the data-processing step of a 32-bit integer datapath. It is purely combinational. The second operand comes either from a register, after a barrel shifter, or from a small zero-extended immediate. That operand is combined with the first register operand by an adder or by a bitwise logic array. The block returns the result, a destination write enable and the next negative/zero/carry/overflow flag set.

The opcode picks one of sixteen operations: moves, arithmetic with and without carry, reverse subtraction, bitwise logic, and four compare forms that only produce flags. The flags change only when the set-flags input is high. An external condition-pass input turns the whole operation into a no-op when it is low. The surrounding pipeline supplies the register values and the current flags, and it commits the outputs.

Top module: `shifted_alu`

## Requirements
- R1: Arithmetic opcodes compute SUB=2 rn-op2, RSB=3 op2-rn, ADD=4 rn+op2, ADC=5 rn+op2+C, SBC=6 rn-op2-(1-C), RSC=7 op2-rn-(1-C). All are modulo 2^32 and appear on `result_o`.
- R2: Logic and move opcodes compute AND=0 rn&op2, EOR=1 rn^op2, ORR=12 rn|op2, MOV=13 op2, BIC=14 rn&~op2, MVN=15 ~op2.
- R3: Compare opcodes TST=8 (and), TEQ=9 (xor), CMP=10 (subtract), CMN=11 (add) never raise `rd_we_o`. Every other opcode raises `rd_we_o` whenever `cond_pass_i` is high. The compare value still appears on `result_o`.
- R4: For arithmetic opcodes with flags set, C (flags bit 1) is the adder carry-out, meaning "no borrow" for subtraction. V (bit 0) flags a signed overflow. Example: 1 minus 1 gives Z=1 and C=1.
- R5: For logic, move and TST/TEQ with flags set, C takes the shifter carry-out and V keeps its input value. Example: MOV of 0x80000004 shifted left by 1 gives 0x00000008 with C=1.
- R6: With `set_flags_i` low, `flags_o` equals `flags_i`.
- R7: With `cond_pass_i` low, `rd_we_o` is low and `flags_o` equals `flags_i`.
- R8: Shift kinds are LSL=0, LSR=1, ASR=2, ROR=3. In register mode only `rs_i[7:0]` is the amount. An amount of 0 passes the operand through unchanged and leaves the shifter carry equal to the C input.
- R9: Register amounts of 32 or more behave as follows. LSL and LSR give 0, with carry equal to bit 0 (LSL) or bit 31 (LSR) at exactly 32, and 0 above 32. ASR fills every bit with bit 31 and takes that bit as carry. ROR by a nonzero multiple of 32 returns the operand with carry equal to bit 31.
- R10: In immediate-amount mode, ROR by 0 is a one-bit rotate right through carry. The C input enters bit 31 and bit 0 becomes the shifter carry.
- R11: With `use_imm_i` high, op2 is `imm_i` zero-extended and the shifter carry equals the C input.
- R12: With flags set and the condition passing, N (bit 3) equals `result_o[31]` and Z (bit 2) is high exactly when `result_o` is zero, for every opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rn_i | input | 32 | First operand |
| rm_i | input | 32 | Register to be shifted into op2 |
| rs_i | input | 32 | Register holding a shift amount |
| imm_i | input | 8 | Immediate op2 value |
| use_imm_i | input | 1 | Select immediate op2 |
| shamt_i | input | 5 | Immediate shift amount |
| shift_kind_i | input | 2 | Shift kind code |
| shift_by_reg_i | input | 1 | Amount from rs_i when high |
| opcode_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Allow flag update |
| flags_i | input | 4 | Current N,Z,C,V (bits 3..0) |
| cond_pass_i | input | 1 | Condition met |
| result_o | output | 32 | Computed value |
| rd_we_o | output | 1 | Destination write enable |
| flags_o | output | 4 | Next N,Z,C,V |

## Verification
The block holds no state. A wrong internal choice therefore shows at the ports in the same evaluation as the input that exercises it. The visible symptoms are a wrong value on `result_o`, a wrong write enable, or a flag that differs from the arithmetic model. The sweeps cover every opcode against many operand, flag and shift combinations. They also cover every shift amount up to and past the operand width, which exposes carry-selection and clamping errors. These are the errors most likely to hide behind plausible-looking results.

// File: rtl/shifted_alu_pkg.sv
package shifted_alu_pkg;
   typedef enum logic [3:0] {
      OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
      OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
      OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
      OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
   } alu_op_e;

   typedef enum logic [1:0] {
      SH_LSL = 2'd0, SH_LSR = 2'd1, SH_ASR = 2'd2, SH_ROR = 2'd3
   } shift_kind_e;

   localparam int FLG_N = 3;
   localparam int FLG_Z = 2;
   localparam int FLG_C = 1;
   localparam int FLG_V = 0;

   function automatic logic op_is_compare(input logic [3:0] op);
      return op[3:2] == 2'b10;
   endfunction

   function automatic logic op_is_arith(input logic [3:0] op);
      return (op inside {4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd10, 4'd11});
   endfunction
endpackage

// File: rtl/shifted_alu_shifter.sv
module shifted_alu_shifter #(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 8,
   localparam int SHW   = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] op_i,
   input  logic [AMT_W-1:0]  amt_i,
   input  logic [1:0]        kind_i,
   input  logic              rrx_i,
   input  logic              cin_i,
   output logic [DATA_W-1:0] out_o,
   output logic              cout_o
);
   import shifted_alu_pkg::*;

   localparam logic [AMT_W-1:0] W_AMT = AMT_W'(DATA_W);

   logic [DATA_W:0]          lsl_w;
   logic [DATA_W:0]          lsr_w;
   logic signed [DATA_W:0]   asr_w;
   logic [2*DATA_W-1:0]      ror_w;
   logic [AMT_W-1:0]         asr_amt;
   logic [SHW-1:0]           ror_amt;

   always_comb begin
      asr_amt = (amt_i >= W_AMT) ? W_AMT : amt_i;
      ror_amt = amt_i[SHW-1:0];
      lsl_w   = {1'b0, op_i} << amt_i;
      lsr_w   = {op_i, 1'b0} >> amt_i;
      asr_w   = $signed({op_i, 1'b0}) >>> asr_amt;
      ror_w   = {op_i, op_i} >> ror_amt;
   end

   always_comb begin
      out_o  = op_i;
      cout_o = cin_i;
      if (rrx_i) begin
         out_o  = {cin_i, op_i[DATA_W-1:1]};
         cout_o = op_i[0];
      end else if (amt_i != '0) begin
         unique case (shift_kind_e'(kind_i))
            SH_LSL: begin out_o = lsl_w[DATA_W-1:0]; cout_o = lsl_w[DATA_W]; end
            SH_LSR: begin out_o = lsr_w[DATA_W:1];   cout_o = lsr_w[0];      end
            SH_ASR: begin out_o = asr_w[DATA_W:1];   cout_o = asr_w[0];      end
            SH_ROR: begin out_o = ror_w[DATA_W-1:0]; cout_o = ror_w[DATA_W-1]; end
            default: begin out_o = op_i; cout_o = cin_i; end
         endcase
      end
   end
endmodule

// File: rtl/shifted_alu_adder.sv
module shifted_alu_adder #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              cin_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              cout_o,
   output logic              ovf_o
);
   logic              c_msb;
   logic [DATA_W-2:0] lo_sum;
   logic              hi_sum;

   always_comb begin
      {c_msb, lo_sum} = {1'b0, a_i[DATA_W-2:0]} + {1'b0, b_i[DATA_W-2:0]}
                        + {{(DATA_W-1){1'b0}}, cin_i};
      {cout_o, hi_sum} = {1'b0, a_i[DATA_W-1]} + {1'b0, b_i[DATA_W-1]} + {1'b0, c_msb};
      sum_o = {hi_sum, lo_sum};
      ovf_o = c_msb ^ cout_o;
   end
endmodule

// File: rtl/shifted_alu.sv
module shifted_alu #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8,
   parameter int AMT_W  = 8,
   localparam int SHW   = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] rn_i,
   input  logic [DATA_W-1:0] rm_i,
   input  logic [DATA_W-1:0] rs_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic              use_imm_i,
   input  logic [SHW-1:0]    shamt_i,
   input  logic [1:0]        shift_kind_i,
   input  logic              shift_by_reg_i,
   input  logic [3:0]        opcode_i,
   input  logic              set_flags_i,
   input  logic [3:0]        flags_i,
   input  logic              cond_pass_i,
   output logic [DATA_W-1:0] result_o,
   output logic              rd_we_o,
   output logic [3:0]        flags_o
);
   import shifted_alu_pkg::*;

   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("shifted_alu: DATA_W must be a power of two of at least 8");
   end
   if (AMT_W <= SHW || AMT_W > DATA_W) begin : g_bad_amt
      $error("shifted_alu: AMT_W must exceed log2(DATA_W) and fit in DATA_W");
   end
   if (IMM_W < 1 || IMM_W > DATA_W) begin : g_bad_imm
      $error("shifted_alu: IMM_W out of range");
   end

   logic [AMT_W-1:0]  sh_amt;
   logic              sh_rrx;
   logic [DATA_W-1:0] sh_out;
   logic              sh_c;
   logic [DATA_W-1:0] op2;
   logic              op2_c;

   always_comb begin
      sh_amt = shift_by_reg_i ? rs_i[AMT_W-1:0] : AMT_W'(shamt_i);
      sh_rrx = !shift_by_reg_i && (shift_kind_i == SH_ROR) && (shamt_i == '0);
   end

   shifted_alu_shifter #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shift (
      .op_i   (rm_i),
      .amt_i  (sh_amt),
      .kind_i (shift_kind_i),
      .rrx_i  (sh_rrx),
      .cin_i  (flags_i[FLG_C]),
      .out_o  (sh_out),
      .cout_o (sh_c)
   );

   always_comb begin
      op2   = use_imm_i ? DATA_W'(imm_i) : sh_out;
      op2_c = use_imm_i ? flags_i[FLG_C] : sh_c;
   end

   logic [DATA_W-1:0] add_a, add_b, add_sum;
   logic              add_cin, add_cout, add_ovf;
   logic [DATA_W-1:0] logic_res;
   logic              arith;

   always_comb begin
      add_a     = rn_i;
      add_b     = op2;
      add_cin   = 1'b0;
      logic_res = op2;
      unique case (alu_op_e'(opcode_i))
         OP_ADD, OP_CMN: begin add_cin = 1'b0; end
         OP_ADC:         begin add_cin = flags_i[FLG_C]; end
         OP_SUB, OP_CMP: begin add_b = ~op2; add_cin = 1'b1; end
         OP_SBC:         begin add_b = ~op2; add_cin = flags_i[FLG_C]; end
         OP_RSB:         begin add_a = op2; add_b = ~rn_i; add_cin = 1'b1; end
         OP_RSC:         begin add_a = op2; add_b = ~rn_i; add_cin = flags_i[FLG_C]; end
         OP_AND, OP_TST: logic_res = rn_i & op2;
         OP_EOR, OP_TEQ: logic_res = rn_i ^ op2;
         OP_ORR:         logic_res = rn_i | op2;
         OP_MOV:         logic_res = op2;
         OP_BIC:         logic_res = rn_i & ~op2;
         OP_MVN:         logic_res = ~op2;
         default:        logic_res = op2;
      endcase
   end

   shifted_alu_adder #(.DATA_W(DATA_W)) u_add (
      .a_i    (add_a),
      .b_i    (add_b),
      .cin_i  (add_cin),
      .sum_o  (add_sum),
      .cout_o (add_cout),
      .ovf_o  (add_ovf)
   );

   always_comb begin
      arith    = op_is_arith(opcode_i);
      result_o = arith ? add_sum : logic_res;
      rd_we_o  = cond_pass_i && !op_is_compare(opcode_i);
      flags_o  = flags_i;
      if (cond_pass_i && set_flags_i) begin
         flags_o[FLG_N] = result_o[DATA_W-1];
         flags_o[FLG_Z] = (result_o == '0);
         flags_o[FLG_C] = arith ? add_cout : op2_c;
         flags_o[FLG_V] = arith ? add_ovf : flags_i[FLG_V];
      end
   end
endmodule

// File: rtl/shifted_alu_chk.sv
module shifted_alu_chk #(
   parameter int DATA_W = 32
) (
   input logic [3:0]        opcode_i,
   input logic              set_flags_i,
   input logic [3:0]        flags_i,
   input logic              cond_pass_i,
   input logic [DATA_W-1:0] result_o,
   input logic              rd_we_o,
   input logic [3:0]        flags_o
);
   import shifted_alu_pkg::*;

   always_comb begin
      if (!$isunknown({opcode_i, set_flags_i, flags_i, cond_pass_i})) begin
         if (!cond_pass_i)
            p_skip_r7: assert (!rd_we_o && flags_o == flags_i)
               else $error("R7: failed condition changed state");
         if (!set_flags_i)
            p_noset_r6: assert (flags_o == flags_i)
               else $error("R6: flags moved with S clear");
         if (op_is_compare(opcode_i))
            p_cmp_nowrite_r3: assert (!rd_we_o)
               else $error("R3: compare wrote destination");
         if (cond_pass_i && !op_is_compare(opcode_i))
            p_write_r3: assert (rd_we_o)
               else $error("R3: missing write");
         if (!op_is_arith(opcode_i))
            p_vkeep_r5: assert (flags_o[FLG_V] == flags_i[FLG_V])
               else $error("R5: logic op touched V");
         if (cond_pass_i && set_flags_i)
            p_nz_r12: assert (flags_o[FLG_N] == result_o[DATA_W-1] &&
                              flags_o[FLG_Z] == (result_o == '0))
               else $error("R12: N/Z disagree with result");
      end
   end
endmodule

bind shifted_alu shifted_alu_chk #(.DATA_W(DATA_W)) u_chk (
   .opcode_i    (opcode_i),
   .set_flags_i (set_flags_i),
   .flags_i     (flags_i),
   .cond_pass_i (cond_pass_i),
   .result_o    (result_o),
   .rd_we_o     (rd_we_o),
   .flags_o     (flags_o)
);

// File: tb/shifted_alu_test.sv
module shifted_alu_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [31:0] rn, rm, rs;
   logic [7:0]  imm;
   logic        use_imm, by_reg, sflag, pass;
   logic [4:0]  shamt;
   logic [1:0]  kind;
   logic [3:0]  opc, flg;
   logic [31:0] result;
   logic        we;
   logic [3:0]  flags_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   shifted_alu uut (
      .rn_i(rn), .rm_i(rm), .rs_i(rs), .imm_i(imm), .use_imm_i(use_imm),
      .shamt_i(shamt), .shift_kind_i(kind), .shift_by_reg_i(by_reg),
      .opcode_i(opc), .set_flags_i(sflag), .flags_i(flg), .cond_pass_i(pass),
      .result_o(result), .rd_we_o(we), .flags_o(flags_out)
   );

   // one-bit-at-a-time reference shifter; returns {carry, value}
   function automatic logic [32:0] ref_sh(input logic [31:0] v, input logic [1:0] k,
                                           input int amt, input logic cin, input logic rrx);
      logic c;
      c = cin;
      if (rrx) return {v[0], cin, v[31:1]};
      for (int i = 0; i < amt; i++) begin
         case (k)
            2'd0: begin c = v[31]; v = v << 1; end
            2'd1: begin c = v[0];  v = v >> 1; end
            2'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
            default: begin c = v[0]; v = {v[0], v[31:1]}; end
         endcase
      end
      return {c, v};
   endfunction

   // returns {we, result, flags}
   function automatic logic [36:0] ref_all();
      logic [31:0] op2, x, y, res;
      logic [32:0] s;
      logic        shc, ci, arith, cmp, ew;
      logic [3:0]  f;
      int          amt;
      logic        rrx;
      if (use_imm) begin
         op2 = {24'd0, imm}; shc = flg[1];
      end else begin
         amt = by_reg ? int'(rs[7:0]) : int'(shamt);
         rrx = !by_reg && kind == 2'd3 && shamt == 5'd0;
         {shc, op2} = ref_sh(rm, kind, amt, flg[1], rrx);
      end
      arith = 1'b1; x = rn; y = op2; ci = 1'b0; res = op2;
      case (opc)
         4'd2, 4'd10: begin y = ~op2; ci = 1'b1; end
         4'd3:  begin x = op2; y = ~rn; ci = 1'b1; end
         4'd4, 4'd11: ci = 1'b0;
         4'd5:  ci = flg[1];
         4'd6:  begin y = ~op2; ci = flg[1]; end
         4'd7:  begin x = op2; y = ~rn; ci = flg[1]; end
         default: arith = 1'b0;
      endcase
      s = {1'b0, x} + {1'b0, y} + {32'd0, ci};
      case (opc)
         4'd0, 4'd8: res = rn & op2;
         4'd1, 4'd9: res = rn ^ op2;
         4'd12: res = rn | op2;
         4'd13: res = op2;
         4'd14: res = rn & ~op2;
         4'd15: res = ~op2;
         default: res = s[31:0];
      endcase
      cmp = (opc >= 4'd8 && opc <= 4'd11);
      ew = pass && !cmp;
      f = flg;
      if (pass && sflag) begin
         f[3] = res[31];
         f[2] = (res == 32'd0);
         f[1] = arith ? s[32] : shc;
         f[0] = arith ? ((x[31] == y[31]) && (res[31] != x[31])) : flg[0];
      end
      return {ew, res, f};
   endfunction

   task automatic check(input string tag, input logic [36:0] exp);
      logic [36:0] got;
      got = {we, result, flags_out};
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: op=%0d got we=%b res=%h f=%b exp we=%b res=%h f=%b",
                  tag, opc, got[36], got[35:4], got[3:0], exp[36], exp[35:4], exp[3:0]);
      end
   endtask

   task automatic step(input string tag);
      @(negedge clk);
      check(tag, ref_all());
      @(posedge clk);
   endtask

   function automatic string tag_of(input logic [3:0] o);
      if (o >= 4'd8 && o <= 4'd11) return "R3 compare";
      if (o >= 4'd2 && o <= 4'd7) return "R1 R4 arith";
      return "R2 R5 logic";
   endfunction

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles exp fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   localparam logic [31:0] VALS [6] = '{32'h0, 32'h1, 32'h7FFF_FFFF,
                                        32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678};

   initial begin : main
      rn = '0; rm = '0; rs = '0; imm = '0; use_imm = 0; by_reg = 0;
      sflag = 0; pass = 1; shamt = '0; kind = 2'd0; opc = 4'd13; flg = 4'b0000;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // reset-state check: idle MOV of zero, flags untouched (R6)
      step("R6 idle");

      // R5 directed: MOV S of 0x80000004 LSL 1
      rm = 32'h8000_0004; shamt = 5'd1; kind = 2'd0; sflag = 1; opc = 4'd13; flg = 4'b0000;
      step("R5 movs lsl1");
      if (result !== 32'h8) begin errors++; $display("FAIL R5: got %h exp 00000008", result); end
      checks++;
      // R4 directed: 1 - 1 sets Z and C
      rn = 32'd1; rm = 32'd1; shamt = 5'd0; opc = 4'd2;
      step("R4 subs 1-1");
      // R7 directed: condition failed
      pass = 0; flg = 4'b1010; opc = 4'd4;
      step("R7 cond fail");
      pass = 1;

      // main sweep: every opcode, operand pair, flag set, S and pass
      for (int o = 0; o < 16; o++)
         for (int a = 0; a < 6; a++)
            for (int b = 0; b < 6; b++)
               for (int f = 0; f < 16; f++)
                  for (int m = 0; m < 4; m++) begin
                     opc = 4'(o); rn = VALS[a]; rm = VALS[b]; flg = 4'(f);
                     sflag = m[0]; pass = m[1]; by_reg = 1;
                     kind = 2'(b % 4); rs = (a == 1) ? 32'd4 : ((a == 2) ? 32'd1 : 32'd0);
                     step(m[1] ? (m[0] ? tag_of(4'(o)) : "R6 no-S") : "R7 skip");
                  end

      // R8 R9: register-amount sweep through MOVS, including high bits of rs ignored
      opc = 4'd13; sflag = 1; pass = 1; by_reg = 1; use_imm = 0;
      for (int k = 0; k < 4; k++)
         for (int amt = 0; amt < 300; amt++)
            for (int v = 0; v < 6; v++)
               for (int c = 0; c < 2; c++) begin
                  kind = 2'(k); rs = 32'hABCD_0000 | 32'(amt); rm = VALS[v];
                  flg = {2'b00, 1'(c), 1'b1};
                  step((amt >= 32) ? "R9 wide shift" : "R8 reg shift");
               end

      // R10 and R8: immediate amounts, ROR #0 is rotate-through-carry
      by_reg = 0;
      for (int k = 0; k < 4; k++)
         for (int amt = 0; amt < 32; amt++)
            for (int v = 0; v < 6; v++)
               for (int c = 0; c < 2; c++) begin
                  kind = 2'(k); shamt = 5'(amt); rm = VALS[v]; flg = {2'b01, 1'(c), 1'b0};
                  step((k == 3 && amt == 0) ? "R10 rrx" : "R8 imm shift");
               end

      // R11: immediate operand with add and move
      use_imm = 1;
      for (int i = 0; i < 256; i += 17)
         for (int o = 0; o < 16; o += 3) begin
            imm = 8'(i); opc = 4'(o); rn = 32'hFFFF_FF80; flg = 4'b0010;
            step("R11 imm op2");
         end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule